// File: doc/BRIEF.md
# Key-Protected Countdown Watchdog with Early Warning

The block is a countdown watchdog behind a small write/read register bank. Software starts it, feeds it and opens or closes its configuration through 16-bit key values written to a single key register. Once running, the watchdog cannot be halted by software. Only feed keys keep it from expiring. On expiry it emits a single-cycle reset request and starts a new period from the reload value.

Timing comes from a tick enable input that stands in for a slow clock. A power-of-two divider turns ticks into counter steps. Changes to the divider and the reload value first land in a shadow register. They reach the counting logic only after a fixed number of ticks, and a busy flag in the status register covers that gap. An early-warning threshold can raise a sticky interrupt. Writing an acknowledge bit clears it, and that write is accepted whether or not configuration is open.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset `rst_req` and `early_irq` are 0 and reads return 0 for divider (0x04), 0xFFF for reload (0x08), 0 for status (0x0C) and 0 for early control (0x14).
- R2: Writes to 0x04, 0x08 and the threshold/enable fields of 0x14 are ignored unless key 0x5555 was the most recent write to key register 0x00. Any other key value, including 0x0000, closes access again.
- R3: Divider field p (bits 2:0 at 0x04) divides ticks by 2^(p+2). A value above MAX_DIV_LOG2-2 is stored and used as MAX_DIV_LOG2-2. The first reset request comes 2^(p+2)*(reload+1) ticks after key 0xCCCC is written.
- R4: Key 0xAAAA written while running restarts the period, so the next reset request comes 2^(p+2)*(reload+1) ticks after that write.
- R5: Before key 0xCCCC, no key value starts counting and no reset request is issued.
- R6: Status bit 0 (divider) and bit 1 (reload) are set by an accepted write to 0x04 or 0x08. Each clears, and the new value takes effect, after SYNC_TICKS ticks. The bit does not clear while `tick` is low.
- R7: With bit 15 of 0x14 set, `early_irq` rises when the counter steps down to the threshold held in bits 11:0. It stays high until a write to 0x14 with bit 14 set, and that write clears it even while access is closed.
- R8: With bit 15 of 0x14 clear, `early_irq` never rises.
- R9: After a reset request the counter reloads and keeps running. The next request follows one full period later.
- R10: `rst_req` is high for exactly one clock cycle per expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Slow time-base enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write byte offset |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 5 | Read byte offset |
| rd_data | output | 16 | Read data, valid the cycle after `rd_en` |
| rst_req | output | 1 | One-cycle reset request on expiry |
| early_irq | output | 1 | Sticky early-warning interrupt |

## Verification
The bench builds the block with MAX_DIV_LOG2 = 8, a 12-bit reload and SYNC_TICKS = 3. A divider of 4 with small reload values keeps each period to a few dozen cycles. Many timed expiries, feeds and threshold hits therefore fit in a short run. The clamping ceiling of 6 lets a divider field of 7 be tried, and the resulting 256-tick divide is still short enough to time in full. Because SYNC_TICKS is small, the busy flags can be caught both set and cleared, including while `tick` is held low.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  localparam logic [DATA_W-1:0] KEY_START = 16'hCCCC;
  localparam logic [DATA_W-1:0] KEY_FEED  = 16'hAAAA;
  localparam logic [DATA_W-1:0] KEY_OPEN  = 16'h5555;

  localparam logic [ADDR_W-1:0] OFS_KEY   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DIV   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_RLD   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_EARLY = 5'h14;

  localparam int EARLY_EN_BIT  = 15;
  localparam int EARLY_ACK_BIT = 14;
endpackage

// File: rtl/wdg_keyctl.sv
module wdg_keyctl
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_val,
  output logic              unlocked,
  output logic              running,
  output logic              load
);
  logic hit_start, hit_feed;

  assign hit_start = key_wr && (key_val == KEY_START);
  assign hit_feed  = key_wr && (key_val == KEY_FEED) && running;
  assign load      = hit_start || hit_feed;

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
      running  <= 1'b0;
    end else begin
      if (key_wr) unlocked <= (key_val == KEY_OPEN);
      if (hit_start) running <= 1'b1;
    end
  end

  // R9: software has no way to stop a started watchdog
  p_run_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    running |=> running);
endmodule

// File: rtl/wdg_sync_reg.sv
module wdg_sync_reg #(
  parameter int W          = 12,
  parameter int SYNC_TICKS = 3,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active,
  output logic         busy
);
  localparam int CW = $clog2(SYNC_TICKS + 1);

  logic [CW-1:0] wait_cnt;

  assign busy = (wait_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow   <= RESET_VAL;
      active   <= RESET_VAL;
      wait_cnt <= '0;
    end else if (wr) begin
      shadow   <= wdata;
      wait_cnt <= CW'(SYNC_TICKS);
    end else if (tick && busy) begin
      wait_cnt <= wait_cnt - CW'(1);
      if (wait_cnt == CW'(1)) active <= shadow;
    end
  end

  // R6: once the busy flag drops, the counting logic holds the written value
  p_apply_on_clear_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (active == $past(shadow)));

  // R6: the busy flag never drops on a cycle without a tick
  p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick && !wr) |=> busy);
endmodule

// File: rtl/wdg_down.sv
module wdg_down #(
  parameter int CNT_W = 12,
  parameter int PR_W  = 3,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             running,
  input  logic             load,
  input  logic [PR_W-1:0]  div_sel,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] thr,
  input  logic             early_en,
  input  logic             early_ack,
  output logic             rst_req,
  output logic             early_irq
);
  logic [DIV_W-1:0] div_cnt, div_top;
  logic [CNT_W-1:0] cnt, cnt_dec;
  logic             step;

  always_comb begin
    div_top = '0;
    for (int i = 0; i < DIV_W; i++)
      if (i < int'(div_sel) + 2) div_top[i] = 1'b1;
  end

  assign step    = running && tick && (div_cnt >= div_top);
  assign cnt_dec = cnt - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      cnt     <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (load) begin
        cnt     <= reload;
        div_cnt <= '0;
      end else if (running && tick) begin
        if (step) begin
          div_cnt <= '0;
          if (cnt == '0) begin
            cnt     <= reload;
            rst_req <= 1'b1;
          end else begin
            cnt <= cnt_dec;
          end
        end else begin
          div_cnt <= div_cnt + DIV_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) early_irq <= 1'b0;
    else if (step && !load && early_en && (cnt != '0) && (cnt_dec == thr))
      early_irq <= 1'b1;
    else if (early_ack)
      early_irq <= 1'b0;
  end

  // R10: a reset request lasts a single cycle
  p_pulse_single_r10: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  // R7: the interrupt holds until acknowledged
  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (early_irq && !early_ack) |=> early_irq);

  // R5: nothing expires while the watchdog is idle
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !running |=> !rst_req);

  // R8: a disabled early warning cannot rise
  p_irq_masked_r8: assert property (@(posedge clk) disable iff (rst)
    (!early_en && !early_irq) |=> !early_irq);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdg_pkg::*;
#(
  parameter int MAX_DIV_LOG2 = 8,
  parameter int RLD_W        = 12,
  parameter int SYNC_TICKS   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rst_req,
  output logic              early_irq
);
  localparam int PR_W = $clog2(MAX_DIV_LOG2 - 1);
  localparam logic [PR_W-1:0]  PR_MAX  = PR_W'(MAX_DIV_LOG2 - 2);
  localparam logic [RLD_W-1:0] RLD_RST = '1;

  logic             unlocked, running, load;
  logic             wr_div, wr_rld, wr_early, ack;
  logic [PR_W-1:0]  pr_in, pr_shadow, pr_active;
  logic [RLD_W-1:0] rld_shadow, rld_active, thr;
  logic             pr_busy, rld_busy, early_en;

  assign wr_div   = wr_en && unlocked && (wr_addr == OFS_DIV);
  assign wr_rld   = wr_en && unlocked && (wr_addr == OFS_RLD);
  assign wr_early = wr_en && unlocked && (wr_addr == OFS_EARLY);
  assign ack      = wr_en && (wr_addr == OFS_EARLY) && wr_data[EARLY_ACK_BIT];
  assign pr_in    = (wr_data[PR_W-1:0] > PR_MAX) ? PR_MAX : wr_data[PR_W-1:0];

  wdg_keyctl u_keys (
    .clk(clk), .rst(rst),
    .key_wr(wr_en && (wr_addr == OFS_KEY)), .key_val(wr_data),
    .unlocked(unlocked), .running(running), .load(load)
  );

  wdg_sync_reg #(.W(PR_W), .SYNC_TICKS(SYNC_TICKS), .RESET_VAL('0)) u_div (
    .clk(clk), .rst(rst), .tick(tick), .wr(wr_div), .wdata(pr_in),
    .shadow(pr_shadow), .active(pr_active), .busy(pr_busy)
  );

  wdg_sync_reg #(.W(RLD_W), .SYNC_TICKS(SYNC_TICKS), .RESET_VAL(RLD_RST)) u_rld (
    .clk(clk), .rst(rst), .tick(tick), .wr(wr_rld), .wdata(wr_data[RLD_W-1:0]),
    .shadow(rld_shadow), .active(rld_active), .busy(rld_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      thr      <= '0;
      early_en <= 1'b0;
    end else if (wr_early) begin
      thr      <= wr_data[RLD_W-1:0];
      early_en <= wr_data[EARLY_EN_BIT];
    end
  end

  wdg_down #(.CNT_W(RLD_W), .PR_W(PR_W), .DIV_W(MAX_DIV_LOG2)) u_down (
    .clk(clk), .rst(rst), .tick(tick), .running(running), .load(load),
    .div_sel(pr_active), .reload(rld_active), .thr(thr),
    .early_en(early_en), .early_ack(ack),
    .rst_req(rst_req), .early_irq(early_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      rd_data <= '0;
      case (rd_addr)
        OFS_DIV:   rd_data[PR_W-1:0] <= pr_shadow;
        OFS_RLD:   rd_data[RLD_W-1:0] <= rld_shadow;
        OFS_STAT:  rd_data[1:0] <= {rld_busy, pr_busy};
        OFS_EARLY: begin
          rd_data[RLD_W-1:0]   <= thr;
          rd_data[EARLY_EN_BIT] <= early_en;
        end
        default:   rd_data <= '0;
      endcase
    end
  end

  // R2: a closed bank ignores configuration writes
  p_locked_rld_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !unlocked && (wr_addr == OFS_RLD)) |=> $stable(rld_shadow));
  p_locked_div_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !unlocked && (wr_addr == OFS_DIV)) |=> $stable(pr_shadow));
  // R3: the stored divider never exceeds the ceiling
  p_div_clamped_r3: assert property (@(posedge clk) disable iff (rst)
    pr_shadow <= PR_MAX);
endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
  localparam int MAXL = 8;

  logic        clk = 0, rst = 1, tick = 1;
  logic        wr_en = 0, rd_en = 0;
  logic [4:0]  wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic        rst_req, early_irq;
  int checks = 0, errors = 0;

  keyed_watchdog #(.MAX_DIV_LOG2(MAXL), .RLD_W(12), .SYNC_TICKS(3)) uut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rst_req(rst_req), .early_irq(early_irq)
  );

  always #2 clk = ~clk;

  function automatic int period(int p, int r);
    return (1 << (p + 2)) * (r + 1);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; tick = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [4:0] a, output int d);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
    d = int'(rd_data);
  endtask

  task automatic cfg(int p, int r, int early);
    wr(5'h00, 16'h5555);
    wr(5'h04, 16'(p));
    wr(5'h08, 16'(r));
    wr(5'h14, 16'(early));
    wr(5'h00, 16'h0000);
    repeat (5) @(negedge clk);
  endtask

  // counts cycles until rst_req, noting the first early_irq cycle
  task automatic run_to_req(int limit, output int n, output int irq_n);
    n = 0; irq_n = -1;
    while (!rst_req && n < limit) begin
      @(negedge clk); n++;
      if (early_irq && irq_n < 0) irq_n = n;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d, n, irq_n, seen;
    void'($urandom(32'd1234));
    do_reset();

    // R1 reset state
    chk("R1 rst_req", int'(rst_req), 0);
    chk("R1 early_irq", int'(early_irq), 0);
    rd(5'h04, d); chk("R1 div", d, 0);
    rd(5'h08, d); chk("R1 reload", d, 12'hFFF);
    rd(5'h0C, d); chk("R1 status", d, 0);
    rd(5'h14, d); chk("R1 early", d, 0);

    // R2 locking
    wr(5'h08, 16'd5);
    rd(5'h08, d); chk("R2 locked write", d, 12'hFFF);
    wr(5'h00, 16'h5555); wr(5'h08, 16'd5);
    rd(5'h08, d); chk("R2 open write", d, 5);
    wr(5'h00, 16'h1234); wr(5'h08, 16'd7);
    rd(5'h08, d); chk("R2 relock other key", d, 5);
    wr(5'h00, 16'h5555); wr(5'h00, 16'h0000); wr(5'h04, 16'd2);
    rd(5'h04, d); chk("R2 relock zero key", d, 0);

    // R6 busy flags
    wr(5'h00, 16'h5555);
    wr(5'h04, 16'd1);
    rd(5'h0C, d); chk("R6 div busy", d, 1);
    repeat (5) @(negedge clk);
    wr(5'h08, 16'd9);
    rd(5'h0C, d); chk("R6 reload busy", d, 2);
    repeat (5) @(negedge clk);
    rd(5'h0C, d); chk("R6 cleared", d, 0);
    tick = 0;
    wr(5'h08, 16'd9);
    repeat (10) @(negedge clk);
    rd(5'h0C, d); chk("R6 held without tick", d, 2);
    tick = 1;
    repeat (5) @(negedge clk);
    rd(5'h0C, d); chk("R6 cleared after ticks", d, 0);

    // R3 timing, R10 pulse width, R9 continued running
    do_reset();
    cfg(0, 5, 0);
    wr(5'h00, 16'hCCCC);
    run_to_req(2000, n, irq_n); chk("R3 first expiry", n, period(0, 5));
    @(negedge clk); chk("R10 single cycle", int'(rst_req), 0);
    n = 1;
    while (!rst_req && n < 2000) begin @(negedge clk); n++; end
    chk("R9 second expiry", n, period(0, 5));

    // R3 clamp
    do_reset();
    wr(5'h00, 16'h5555); wr(5'h04, 16'd7);
    rd(5'h04, d); chk("R3 clamp read", d, MAXL - 2);
    cfg(7, 2, 0);
    wr(5'h00, 16'hCCCC);
    run_to_req(5000, n, irq_n); chk("R3 clamped expiry", n, period(MAXL - 2, 2));

    // R4 feed
    do_reset();
    cfg(1, 9, 0);
    wr(5'h00, 16'hCCCC);
    seen = 0;
    repeat (50) begin @(negedge clk); if (rst_req) seen = 1; end
    chk("R4 no expiry before feed", seen, 0);
    wr(5'h00, 16'hAAAA);
    run_to_req(2000, n, irq_n); chk("R4 period after feed", n, period(1, 9));

    // R5 keys before start
    do_reset();
    cfg(0, 2, 0);
    wr(5'h00, 16'hAAAA); wr(5'h00, 16'h1234);
    seen = 0;
    repeat (100) begin @(negedge clk); if (rst_req) seen = 1; end
    chk("R5 idle before start", seen, 0);
    wr(5'h00, 16'hCCCC);
    run_to_req(2000, n, irq_n); chk("R5 start after idle", n, period(0, 2));

    // R7 early warning, ack while locked
    do_reset();
    cfg(0, 10, 16'h8004);
    wr(5'h00, 16'hCCCC);
    n = 0;
    while (!early_irq && n < 2000) begin @(negedge clk); n++; end
    chk("R7 irq time", n, 4 * (10 - 4));
    repeat (30) @(negedge clk);
    chk("R7 irq held", int'(early_irq), 1);
    wr(5'h14, 16'h4000);
    chk("R7 ack clears", int'(early_irq), 0);
    rd(5'h14, d); chk("R7 locked ack keeps fields", d, 16'h8004);

    // R8 masked
    do_reset();
    cfg(0, 10, 16'h0004);
    wr(5'h00, 16'hCCCC);
    seen = 0;
    repeat (100) begin @(negedge clk); if (early_irq) seen = 1; end
    chk("R8 masked irq", seen, 0);

    // random periods and thresholds (R3, R7)
    for (int k = 0; k < 8; k++) begin
      int p, r, t;
      p = int'($urandom % 3);
      r = 2 + int'($urandom % 14);
      t = int'($urandom % r);
      do_reset();
      cfg(p, r, 16'h8000 | t);
      wr(5'h00, 16'hCCCC);
      run_to_req(5000, n, irq_n);
      chk("R3 random expiry", n, period(p, r));
      chk("R7 random irq", irq_n, (1 << (p + 2)) * (r - t));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule